// File: doc/BRIEF.md
# Mode-Selectable Byte Port with Service-Request Handshake

This block is a parallel byte port that a static mode input configures as either an input port or an output port. A single data register captures the `data_in` byte while a strobe line is high and keeps it once the strobe falls. The register is always visible on `data_out`, and a separate `data_oe` says whether that byte should be driven onto a shared bus. A service-request output, `svc_req_o`, gives a handshake. Its set and clear events, and its resting level, depend on the mode.

In input mode a peripheral strobes a byte in, and `svc_req_o` goes low to tell the host that data is waiting. The host selects the port by driving both selects high, which enables the output and lets it read the byte. Deselection ends the read and returns `svc_req_o` high. In output mode the host selects the port (`sel1_i` low, `sel2_i` high) and strobes a byte in, and the output stays enabled at all times. When the host deselects the port, `svc_req_o` goes high to signal the peripheral. It goes low again on the next falling strobe edge.

The block runs on a fast system clock. The strobe passes through a synchronizer and its falling edge is detected, so no latch is built. While a load is qualified, the register reloads on every system cycle, which gives the transparent follow-while-high behaviour. The selects are assumed synchronous to the system clock. The mode is assumed to change only while reset or clear is applied.

Top module: `byte_port_hs`

## Requirements
- R1: `mode_i`=0 gives input mode, in which the port is selected when `sel1_i`=1 and `sel2_i`=1. `mode_i`=1 gives output mode, in which the port is selected when `sel1_i`=0 and `sel2_i`=1.
- R2: In input mode the register reloads from `data_in` on every cycle while the synchronized strobe is high. It keeps the last loaded byte after the strobe falls, whatever `data_in` does afterwards.
- R3: In input mode a falling strobe edge drives `svc_req_o` low SYNC_STAGES+1 clock cycles after the strobe input falls.
- R4: In input mode `data_oe` is high exactly while the port is selected.
- R5: In input mode a selected-to-deselected transition returns `svc_req_o` high on the next clock edge.
- R6: In output mode `data_oe` is always high, whatever the selects are.
- R7: In output mode the register loads only while the port is selected and the synchronized strobe is high. A strobe while the port is deselected leaves `data_out` unchanged.
- R8: In output mode a selected-to-deselected transition drives `svc_req_o` high on the next clock edge, and the next falling strobe edge drives it low again.
- R9: Driving `clr_n` low immediately and asynchronously sets the register to 0 and puts `svc_req_o` at its idle level: high in input mode, low in output mode.
- R10: `rst_n` low at a clock edge gives the same state as R9, synchronously.
- R11: If a set event and a clear event of the service request fall in the same cycle, the set event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear |
| mode_i | input | 1 | 0 = input port, 1 = output port |
| sel1_i | input | 1 | Select 1; its polarity depends on the mode |
| sel2_i | input | 1 | Select 2, active high |
| strobe_i | input | 1 | Load strobe, asynchronous to clk |
| data_in | input | WIDTH | Byte to capture |
| data_out | output | WIDTH | Register contents |
| data_oe | output | 1 | Output-drive enable for data_out |
| svc_req_o | output | 1 | Service-request handshake output |

## Verification
The bench builds the block with WIDTH=8 and SYNC_STAGES=2. With those values, distinct byte patterns separate a reload from a held value, and the service-request response lands exactly three cycles after the strobe falls, so every timing check can be sampled on one known cycle. Both modes are run from reset, and each select polarity is driven in each mode. Strobes are applied while the port is selected and while it is deselected, so both the gating and the handshake edges can be observed.

// File: rtl/byte_port_pkg.sv
// Shared types and helpers for the byte port.
// Assumes the mode is static between resets.
package byte_port_pkg;

    typedef enum logic {
        PORT_IN  = 1'b0,
        PORT_OUT = 1'b1
    } port_mode_e;

    // Select decode: select 1 is active high in input mode, active low in output mode.
    function automatic logic port_selected(port_mode_e m, logic s1, logic s2);
        return (m == PORT_OUT) ? (~s1 & s2) : (s1 & s2);
    endfunction

endpackage

// File: rtl/bp_edge_sync.sv
// Synchronizes an asynchronous strobe into the clk domain and flags its falling edge.
// Assumes STAGES >= 2. fall_o is a one-cycle pulse.
module bp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic async_i,
    output logic level_o,
    output logic fall_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift chain: STAGES synchronizer flops plus one history flop for edge detection.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      chain_q <= '0;
        else if (!rst_n) chain_q <= '0;
        else             chain_q <= {chain_q[CHAIN-2:0], async_i};
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];

    // R3: a falling-edge flag never lasts two cycles.
    a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/bp_data_reg.sv
// Port data register: reloads every cycle while load_i is high, else holds.
// Assumes din_i is synchronous or stable while loading.
module bp_data_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] q_o
);
    // Data storage with asynchronous clear and synchronous reset.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      q_o <= '0;
        else if (!rst_n) q_o <= '0;
        else if (load_i) q_o <= din_i;
    end

    // R2: a qualified load captures the byte present at that edge.
    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        load_i |=> (q_o == $past(din_i)));

    // R7: without a load the register keeps its value.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !load_i |=> $stable(q_o));

endmodule

// File: rtl/bp_srq_ctl.sv
// Select decode, output-enable control and the service-request flag for both modes.
// Assumes the selects are synchronous to clk and the mode is static outside reset.
module bp_srq_ctl
    import byte_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic mode_i,
    input  logic sel1_i,
    input  logic sel2_i,
    input  logic fall_i,
    output logic selected_o,
    output logic oe_o,
    output logic srq_o
);
    port_mode_e mode;
    logic       sel_q;
    logic       desel;
    logic       req_q;

    assign mode       = port_mode_e'(mode_i);
    assign selected_o = port_selected(mode, sel1_i, sel2_i);
    assign desel      = sel_q & ~selected_o;
    assign oe_o       = (mode == PORT_OUT) | selected_o;

    // Previous select state, used to find the deselect transition.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      sel_q <= 1'b0;
        else if (!rst_n) sel_q <= 1'b0;
        else             sel_q <= selected_o;
    end

    // Request flag: the set event has priority over the clear event in both modes.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)                  req_q <= 1'b0;
        else if (!rst_n)             req_q <= 1'b0;
        else if (mode == PORT_IN) begin
            if (fall_i)              req_q <= 1'b1;
            else if (desel)          req_q <= 1'b0;
        end else begin
            if (desel)               req_q <= 1'b1;
            else if (fall_i)         req_q <= 1'b0;
        end
    end

    // Active request is low in input mode and high in output mode.
    assign srq_o = (mode == PORT_OUT) ? req_q : ~req_q;

    // R3, R11: an input-mode falling strobe raises the request.
    a_r3_in_set: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!mode_i && fall_i) |=> req_q);

    // R5: an input-mode deselect without a strobe edge drops the request.
    a_r5_in_clear: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!mode_i && desel && !fall_i) |=> !req_q);

    // R8, R11: an output-mode deselect raises the request.
    a_r8_out_set: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (mode_i && desel) |=> req_q);

    // R8: an output-mode falling strobe drops the request when no deselect coincides.
    a_r8_out_clear: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (mode_i && fall_i && !desel) |=> !req_q);

endmodule

// File: rtl/byte_port_hs.sv
// Top of the mode-selectable byte port. Ties the strobe synchronizer, data register
// and request control together and qualifies register loads by mode and select.
module byte_port_hs
    import byte_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             mode_i,
    input  logic             sel1_i,
    input  logic             sel2_i,
    input  logic             strobe_i,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] data_out,
    output logic             data_oe,
    output logic             svc_req_o
);
    logic stb_level;
    logic stb_fall;
    logic selected;
    logic load;

    bp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .async_i (strobe_i),
        .level_o (stb_level),
        .fall_o  (stb_fall)
    );

    bp_srq_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_n      (clr_n),
        .mode_i     (mode_i),
        .sel1_i     (sel1_i),
        .sel2_i     (sel2_i),
        .fall_i     (stb_fall),
        .selected_o (selected),
        .oe_o       (data_oe),
        .srq_o      (svc_req_o)
    );

    // Load qualification: any strobe in input mode, only a selected strobe in output mode.
    assign load = stb_level & ((port_mode_e'(mode_i) == PORT_IN) | selected);

    bp_data_reg #(.WIDTH(WIDTH)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .load_i (load),
        .din_i  (data_in),
        .q_o    (data_out)
    );

    // R6: output mode always drives.
    a_r6_out_oe: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        mode_i |-> data_oe);

    // R4: in input mode, a missing select releases the bus.
    a_r4_in_release: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!mode_i && !(sel1_i && sel2_i)) |-> !data_oe);

endmodule

// File: tb/byte_port_hs_tb.sv
module byte_port_hs_tb;
    localparam int W  = 8;
    localparam int SS = 2;

    logic         clk = 1'b0;
    logic         rst_n, clr_n, mode_i, sel1_i, sel2_i, strobe_i;
    logic [W-1:0] data_in, data_out;
    logic         data_oe, svc_req_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    byte_port_hs #(.WIDTH(W), .SYNC_STAGES(SS)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .mode_i(mode_i),
        .sel1_i(sel1_i), .sel2_i(sel2_i), .strobe_i(strobe_i),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .svc_req_o(svc_req_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic m, input logic s1, input logic s2);
        mode_i = m; sel1_i = s1; sel2_i = s2; strobe_i = 0; data_in = 8'hFF;
        clr_n = 1; rst_n = 0;
        step(2);
        rst_n = 1;
        step(1);
    endtask

    // Strobe pulse: high long enough to load, then low until the edge is processed.
    task automatic pulse(input logic [W-1:0] d);
        data_in = d; strobe_i = 1;
        step(SS + 2);
        strobe_i = 0;
        step(SS + 2);
    endtask

    task automatic t_in_reset;
        do_reset(1'b0, 1'b0, 1'b0);
        chk("R10 data after reset", data_out, 8'h00);
        chk("R10 srq idle high input mode", {7'd0, svc_req_o}, 8'd1);
        chk("R4 oe low when deselected", {7'd0, data_oe}, 8'd0);
    endtask

    task automatic t_in_capture;
        data_in = 8'hA5; strobe_i = 1;
        step(SS + 1);
        chk("R2 follows while strobe high", data_out, 8'hA5);
        data_in = 8'h3C;
        step(1);
        chk("R2 follows new byte", data_out, 8'h3C);
        chk("R3 srq high before fall", {7'd0, svc_req_o}, 8'd1);
        strobe_i = 0;
        step(SS);
        chk("R3 srq not yet low", {7'd0, svc_req_o}, 8'd1);
        step(1);
        chk("R3 srq low after fall", {7'd0, svc_req_o}, 8'd0);
        data_in = 8'h99;
        step(3);
        chk("R2 held after fall", data_out, 8'h3C);
    endtask

    task automatic t_in_select;
        sel1_i = 0; sel2_i = 1; #1;
        chk("R1 input mode wrong polarity not selected", {7'd0, data_oe}, 8'd0);
        sel1_i = 1; sel2_i = 1; #1;
        chk("R4 oe high when selected", {7'd0, data_oe}, 8'd1);
        step(2);
        chk("R5 srq stays low while selected", {7'd0, svc_req_o}, 8'd0);
        sel2_i = 0; #1;
        chk("R4 oe drops on deselect", {7'd0, data_oe}, 8'd0);
        step(1);
        chk("R5 srq high after deselect", {7'd0, svc_req_o}, 8'd1);
        chk("R4 data kept for read", data_out, 8'h3C);
    endtask

    task automatic t_in_clear;
        pulse(8'h11);
        chk("R3 srq low before clear", {7'd0, svc_req_o}, 8'd0);
        #0.5 clr_n = 0; #0.5;
        chk("R9 clear data async", data_out, 8'h00);
        chk("R9 clear srq high input mode", {7'd0, svc_req_o}, 8'd1);
        step(2);
        clr_n = 1;
        step(1);
    endtask

    task automatic t_out_basic;
        do_reset(1'b1, 1'b1, 1'b1);
        chk("R10 srq idle low output mode", {7'd0, svc_req_o}, 8'd0);
        chk("R6 oe high deselected", {7'd0, data_oe}, 8'd1);
        pulse(8'h5A);
        chk("R1 output mode sel1 high not selected, R7 no load", data_out, 8'h00);
        sel1_i = 0; sel2_i = 1; #1;
        chk("R6 oe high selected", {7'd0, data_oe}, 8'd1);
        pulse(8'hC3);
        chk("R7 load when selected", data_out, 8'hC3);
        chk("R8 srq low while selected", {7'd0, svc_req_o}, 8'd0);
    endtask

    task automatic t_out_handshake;
        sel1_i = 1; #1;
        step(1);
        chk("R8 srq high after deselect", {7'd0, svc_req_o}, 8'd1);
        step(3);
        chk("R8 srq stays high", {7'd0, svc_req_o}, 8'd1);
        data_in = 8'h77; strobe_i = 1;
        step(SS + 2);
        chk("R7 no load while deselected", data_out, 8'hC3);
        strobe_i = 0;
        step(SS + 1);
        chk("R8 srq low after falling strobe", {7'd0, svc_req_o}, 8'd0);
    endtask

    task automatic t_out_clear;
        sel1_i = 0; step(2); sel1_i = 1; step(1);
        chk("R8 srq high before clear", {7'd0, svc_req_o}, 8'd1);
        #0.5 clr_n = 0; #0.5;
        chk("R9 clear data output mode", data_out, 8'h00);
        chk("R9 clear srq low output mode", {7'd0, svc_req_o}, 8'd0);
        step(2);
        clr_n = 1;
        step(1);
    endtask

    // Same-cycle set and clear in output mode: deselect coinciding with fall processing.
    task automatic t_out_priority;
        sel1_i = 0; sel2_i = 1; #1;
        data_in = 8'h42; strobe_i = 1;
        step(SS + 2);
        strobe_i = 0;
        step(SS);
        sel1_i = 1;
        step(1);
        chk("R11 set wins over fall clear", {7'd0, svc_req_o}, 8'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; clr_n = 1; mode_i = 0; sel1_i = 0; sel2_i = 0;
        strobe_i = 0; data_in = '0;
        t_in_reset;
        t_in_capture;
        t_in_select;
        t_in_clear;
        t_out_basic;
        t_out_handshake;
        t_out_clear;
        t_out_priority;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule